// File: doc/BRIEF.md
# Free-Running Acquisition Sequencer with Frame-Drop Idle Cycles

The block runs a detector with no trigger. It times integration periods back to back, each one `int_len` clock cycles long. At the end of each period it decides one of two things. If the one-frame output buffer is free, it asks the detector to transfer the pixels it has collected and stores them as they stream in. If the buffer is not free, it tells the detector to discard its charge and spends one whole period idle. The next integration runs while the previous frame is being stored and while the host drains it.

The host reads the stored frame pixel by pixel with a read strobe and watches an empty flag. The block never stalls and never overwrites an unread frame. A frame it cannot hold is dropped through an idle period, and a saturating counter records each idle period.

The sequencer has two states. `ST_INTEG` is an integration period and `ST_IDLE` is an idle period. A transition happens only in the last cycle of a period, and there are four of them:
- `T_BACK2BACK` (ST_INTEG→ST_INTEG, buffer free): pulses `det_xfer`.
- `T_DROP` (ST_INTEG→ST_IDLE, buffer busy): pulses `det_dump`.
- `T_RETRY` (ST_IDLE→ST_IDLE, buffer still busy).
- `T_RESUME` (ST_IDLE→ST_INTEG, buffer free).

Top module: `acq_seq`

## Requirements
- R1: In the first cycle after synchronous reset is released, `buf_empty` is 1, `drop_cnt` is 0, the state is `ST_INTEG` and `det_start` is 1.
- R2: Each period lasts max(`int_len`,1) cycles. `int_len` is sampled only in the last cycle of a period, or during reset, and it applies to the following period. `det_start` is high in the first cycle of every integration and the next period begins in the cycle after the last one.
- R3: If the buffer is free (empty and no capture pending) in the last cycle of an integration, `det_xfer` is high in that cycle and another integration follows (`T_BACK2BACK`).
- R4: If the buffer is not free in the last cycle of an integration, `det_dump` is high in that cycle and one idle period follows (`T_DROP`). During an idle period `det_start`, `det_xfer` and `det_dump` stay low.
- R5: In the last cycle of an idle period, the sequencer takes `T_RESUME` if the buffer is free, so `det_start` is high in the next cycle. Otherwise it takes `T_RETRY` and idles for another period.
- R6: After `det_xfer`, the next NPIX cycles with `pix_valid` high store `pix_data` in arrival order. A `pix_valid` outside a capture window changes nothing the host can read.
- R7: `buf_empty` falls in the cycle after the first pixel of a frame is stored. It rises in the cycle after the host reads pixel NPIX-1.
- R8: `rd_data` shows the oldest unread stored pixel while the buffer is not empty, and 0 when it is empty. `rd_en` is accepted only when a stored pixel is still unread; an accepted read moves to the next pixel.
- R9: `drop_cnt` increases by one on every entry to an idle period (`T_DROP` or `T_RETRY`) and holds at 2^DROP_W-1.
- R10: `det_xfer` and `det_dump` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| int_len | input | CNT_W (20) | Period length in cycles; 0 is treated as 1 |
| pix_valid | input | 1 | Detector pixel strobe |
| pix_data | input | DW (16) | Detector pixel value |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DW (16) | Oldest unread pixel, 0 when empty |
| buf_empty | output | 1 | Frame buffer empty flag |
| det_start | output | 1 | Integration start pulse |
| det_xfer | output | 1 | Transfer-pixels pulse to the detector |
| det_dump | output | 1 | Discard-charge pulse to the detector |
| drop_cnt | output | DROP_W (8) | Saturating count of idle periods |

## Verification
The embedded properties assume three things about the inputs. First, the detector sends pixels only after `det_xfer`; the block drops any it sends at other times. Second, `rd_en` may be raised at any time, since the block ignores reads that have nothing to return. Third, reset is held for at least one clock edge before any check begins.

The stimulus uses random draws with a fixed seed. It includes stray pixel strobes outside capture windows, reads of a buffer that is empty or only partly filled, period lengths of 0 and 1, and changes to the length in the middle of a period. Directed phases starve the host until the drop counter saturates, then drain the buffer with long periods, and finally reset the block in the middle of operation.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [0:0] {
        ST_INTEG = 1'b0,
        ST_IDLE  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/acq_fsm.sv
module acq_fsm
    import acq_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  int_len,
    input  logic              buf_free,
    output logic              det_start,
    output logic              det_xfer,
    output logic              det_dump,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt, len_q, len_in;
    logic             at_end;
    logic             started;

    assign len_in = (int_len == '0) ? ONE : int_len;
    assign at_end = (cnt == len_q - ONE);

    // next-state decision, only taken in the last cycle of a period
    always_comb begin
        nxt = state;
        if (at_end) begin
            unique case (state)
                ST_INTEG: nxt = buf_free ? ST_INTEG : ST_IDLE;  // T_BACK2BACK / T_DROP
                ST_IDLE:  nxt = buf_free ? ST_INTEG : ST_IDLE;  // T_RESUME / T_RETRY
                default:  nxt = ST_INTEG;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_INTEG;
            cnt      <= '0;
            len_q    <= len_in;
            drop_cnt <= '0;
            started  <= 1'b0;
        end else begin
            started <= 1'b1;
            if (at_end) begin
                cnt   <= '0;
                len_q <= len_in;
                state <= nxt;
                if (nxt == ST_IDLE && drop_cnt != DROP_MAX)
                    drop_cnt <= drop_cnt + 1'b1;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    // outputs
    always_comb begin
        det_start = 1'b0;
        det_xfer  = 1'b0;
        det_dump  = 1'b0;
        unique case (state)
            ST_INTEG: begin
                det_start = (cnt == '0);
                det_xfer  = at_end && buf_free;
                det_dump  = at_end && !buf_free;
            end
            ST_IDLE: ;
            default: ;
        endcase
    end

    // R10: transfer and discard are exclusive
    p_excl_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        !(det_xfer && det_dump));

    // R4: an idle period is silent towards the detector
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!det_start && !det_xfer && !det_dump));

    // R9: the drop counter moves by at most one and only on entering idle
    p_drop_step_r9: assert property (@(posedge clk) disable iff (rst)
        (started && drop_cnt != $past(drop_cnt)) |->
            (drop_cnt == $past(drop_cnt) + 1'b1 && state == ST_IDLE && $past(at_end)));

    // R5: leaving a period with a free buffer starts an integration
    p_resume_r5: assert property (@(posedge clk) disable iff (rst)
        (at_end && buf_free) |=> det_start);
endmodule

// File: rtl/acq_frame_buf.sv
module acq_frame_buf #(
    parameter int NPIX = 16,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          buf_empty,
    output logic          buf_free
);
    localparam int PTR_W = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int CW    = $clog2(NPIX + 1);
    localparam logic [CW-1:0] LAST = CW'(NPIX - 1);

    logic [DW-1:0] mem [NPIX];
    logic          cap;
    logic [CW-1:0] wr_cnt, rd_ptr;
    logic          wr_fire, rd_fire;
    logic          started;

    assign wr_fire  = cap && pix_valid;
    assign rd_fire  = rd_en && !buf_empty && (rd_ptr < wr_cnt);
    assign buf_free = buf_empty && !cap;
    assign rd_data  = buf_empty ? '0 : mem[PTR_W'(rd_ptr)];

    always_ff @(posedge clk) begin
        if (wr_fire)
            mem[PTR_W'(wr_cnt)] <= pix_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap       <= 1'b0;
            wr_cnt    <= '0;
            rd_ptr    <= '0;
            buf_empty <= 1'b1;
            started   <= 1'b0;
        end else begin
            started <= 1'b1;
            if (xfer) begin
                cap    <= 1'b1;
                wr_cnt <= '0;
                rd_ptr <= '0;
            end else if (wr_fire) begin
                wr_cnt    <= wr_cnt + 1'b1;
                buf_empty <= 1'b0;
                if (wr_cnt == LAST)
                    cap <= 1'b0;
            end
            if (rd_fire) begin
                rd_ptr <= rd_ptr + 1'b1;
                if (rd_ptr == LAST)
                    buf_empty <= 1'b1;
            end
        end
    end

    // R3: a transfer is only requested into a free buffer
    p_no_overwrite_r3: assert property (@(posedge clk) disable iff (rst)
        xfer |-> buf_free);

    // R7: empty rises only after reading the last pixel
    p_empty_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (started && $rose(buf_empty)) |-> ($past(rd_fire) && $past(rd_ptr) == LAST));

    // R7: empty falls only after a pixel was stored
    p_empty_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (started && $fell(buf_empty)) |-> $past(wr_fire));

    // R8: the host never reads beyond what was written
    p_rd_behind_wr_r8: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= wr_cnt);
endmodule

// File: rtl/acq_seq.sv
module acq_seq #(
    parameter int CNT_W  = 20,
    parameter int NPIX   = 16,
    parameter int DW     = 16,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  int_len,
    input  logic              pix_valid,
    input  logic [DW-1:0]     pix_data,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    output logic              buf_empty,
    output logic              det_start,
    output logic              det_xfer,
    output logic              det_dump,
    output logic [DROP_W-1:0] drop_cnt
);
    logic buf_free;

    acq_fsm #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .int_len   (int_len),
        .buf_free  (buf_free),
        .det_start (det_start),
        .det_xfer  (det_xfer),
        .det_dump  (det_dump),
        .drop_cnt  (drop_cnt)
    );

    acq_frame_buf #(.NPIX(NPIX), .DW(DW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .xfer      (det_xfer),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .buf_empty (buf_empty),
        .buf_free  (buf_free)
    );
endmodule

// File: tb/test_acq_seq.sv
module test_acq_seq;
    localparam int CNT_W  = 20;
    localparam int NPIX   = 16;
    localparam int DW     = 16;
    localparam int DROP_W = 8;
    localparam int DMAX   = (1 << DROP_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  int_len = 20'd3;
    logic              pix_valid = 1'b0;
    logic [DW-1:0]     pix_data = '0;
    logic              rd_en = 1'b0;
    logic [DW-1:0]     rd_data;
    logic              buf_empty, det_start, det_xfer, det_dump;
    logic [DROP_W-1:0] drop_cnt;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    acq_seq #(.CNT_W(CNT_W), .NPIX(NPIX), .DW(DW), .DROP_W(DROP_W)) i_acq_seq (
        .clk(clk), .rst(rst), .int_len(int_len), .pix_valid(pix_valid),
        .pix_data(pix_data), .rd_en(rd_en), .rd_data(rd_data),
        .buf_empty(buf_empty), .det_start(det_start), .det_xfer(det_xfer),
        .det_dump(det_dump), .drop_cnt(drop_cnt)
    );

    // reference model state
    int      m_state, m_cnt, m_len, m_drop, m_wr, m_rd;
    bit      m_cap, m_empty;
    int      m_mem [NPIX];

    function automatic int clamp_len(int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic bit e_free();
        return m_empty && !m_cap;
    endfunction
    function automatic bit e_end();
        return m_cnt == m_len - 1;
    endfunction
    function automatic bit e_start();
        return m_state == 0 && m_cnt == 0;
    endfunction
    function automatic bit e_xfer();
        return m_state == 0 && e_end() && e_free();
    endfunction
    function automatic bit e_dump();
        return m_state == 0 && e_end() && !e_free();
    endfunction
    function automatic int e_rdata();
        return m_empty ? 0 : m_mem[m_rd];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_cnt = 0; m_len = clamp_len(int'(int_len)); m_drop = 0;
        m_cap = 0; m_wr = 0; m_rd = 0; m_empty = 1;
    endtask

    task automatic model_step(input int len_in, input bit pv, input int pd, input bit re);
        bit fr, en, xf, wr, rf;
        fr = e_free(); en = e_end(); xf = e_xfer();
        wr = m_cap && pv;
        rf = re && !m_empty && (m_rd < m_wr);
        if (en) begin
            m_cnt = 0; m_len = clamp_len(len_in);
            if (fr) m_state = 0;
            else begin
                m_state = 1;
                if (m_drop != DMAX) m_drop++;
            end
        end else m_cnt++;
        if (xf) begin
            m_cap = 1; m_wr = 0; m_rd = 0;
        end else if (wr) begin
            m_mem[m_wr] = pd;
            if (m_wr == NPIX - 1) m_cap = 0;
            m_wr++;
            m_empty = 0;
        end
        if (rf) begin
            if (m_rd == NPIX - 1) m_empty = 1;
            m_rd++;
        end
    endtask

    task automatic compare();
        chk(det_start === e_start(), "R2 det_start", det_start, e_start());
        chk(det_xfer === e_xfer(), "R3 det_xfer", det_xfer, e_xfer());
        chk(det_dump === e_dump(), "R4 det_dump", det_dump, e_dump());
        chk(buf_empty === m_empty, "R7 buf_empty", buf_empty, m_empty);
        chk(int'(drop_cnt) == m_drop, "R9 drop_cnt", drop_cnt, m_drop);
        chk(int'(rd_data) == e_rdata(), "R8 rd_data", rd_data, e_rdata());
        chk(!(det_xfer && det_dump), "R10 exclusive", det_xfer & det_dump, 0);
    endtask

    // one cycle: check, drive, advance model, wait
    task automatic run(input int n, input int rd_pct, input int pix_pct, input int stray_pct,
                       input int len_max, input int len_chg_pct);
        for (int i = 0; i < n; i++) begin
            bit pv, re;
            int pd, ln;
            compare();
            ln = int'(int_len);
            if (($urandom % 100) < len_chg_pct) ln = $urandom % (len_max + 1);
            pv = m_cap ? (($urandom % 100) < pix_pct) : (($urandom % 100) < stray_pct);
            pd = $urandom % (1 << DW);
            re = ($urandom % 100) < rd_pct;
            int_len = CNT_W'(ln); pix_valid = pv; pix_data = DW'(pd); rd_en = re;
            model_step(ln, pv, pd, re);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pix_valid = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
        // R1: state right after release
        chk(buf_empty === 1'b1, "R1 empty after reset", buf_empty, 1);
        chk(drop_cnt == '0, "R1 drop_cnt after reset", drop_cnt, 0);
        chk(det_start === 1'b1, "R1 det_start first cycle", det_start, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        int_len = 20'd3;
        do_reset();
        // R2: zero length treated as one, back-to-back pulses
        int_len = 20'd0;
        run(40, 100, 100, 0, 0, 0);
        // R2 R3 R4 R5 R6: mixed random traffic with stray pixels and length changes
        run(4000, 50, 70, 10, 8, 5);
        // R4 R5 R9: host starves, short periods, counter saturates
        int_len = 20'd1;
        run(700, 0, 90, 20, 1, 0);
        chk(int'(drop_cnt) == DMAX, "R9 saturation", drop_cnt, DMAX);
        // R5 R7 R8: drain with long periods so T_RESUME follows
        int_len = 20'd40;
        run(2000, 100, 60, 30, 40, 0);
        // random again with slow host
        run(3000, 15, 80, 15, 12, 10);
        // R1: reset in the middle of operation
        int_len = 20'd5;
        do_reset();
        run(500, 40, 70, 10, 6, 5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule